// File: doc/BRIEF.md
# Semaphore Command Evaluator

This block keeps a bank of small counting semaphores and executes 32-bit command words presented by one or more request sequencers. A command can name a semaphore and an operation on it, such as loading a value, counting up or down, blocking until a value is reached, or a take that waits for a positive count and then consumes one. It can also carry two fences that hold it back while transfers in either direction are still in flight. The unit answers each command with a one-cycle grant. A grant means the command's condition held in that cycle and its effect is written at the next clock edge.

A sequencer keeps its command valid until it sees a grant. It also tells the unit which stage it is in: before its transfer or after it. A command tagged for the other stage passes straight through. The counts of outstanding transfers in each direction come in as inputs. Compute agents change semaphores through a side port. A read port shows any semaphore's current value. When several channels can complete in the same cycle, the lowest-numbered channel wins.

Top module: `sem_cmd_unit`

## Requirements
- R1: A valid command with bit 31 clear is granted in the same cycle, even with fence bits set and transfers outstanding, and changes no semaphore.
- R2: Bit 22 marks a command as pre-transfer (1) or post-transfer (0). If it differs from the channel's `stage_pre` input, the command is granted at once with no effect and no fencing.
- R3: When a command is active (enabled and stage-matched), bit 30 holds its grant while `to_dev_pend` is non-zero, and bit 29 holds it while `from_dev_pend` is non-zero.
- R4: Bits 26:24 give the operation. Code 0 does nothing. Code 1 loads the semaphore selected by bits 20:16 (low log2(NSEM) bits) with the operand in bits 11:0, visible on the read port after the grant edge.
- R5: Code 2 adds one, saturating at 4095. Code 3 subtracts one, saturating at 0.
- R6: Code 4 waits until the semaphore equals the operand. Code 5 waits until it is greater than or equal to the operand. The condition is re-checked every cycle, and the grant comes in the first cycle it holds.
- R7: Code 6 waits until the semaphore is non-zero. It is then granted, and the semaphore is one lower after that edge.
- R8: Code 7 is granted with `grant_err` high for that channel and leaves the semaphore unchanged.
- R9: At most one grant per cycle. It goes to the lowest-indexed channel whose command is valid and ready, and a grant is never given to an invalid channel.
- R10: The side port acts at the next edge on `side_idx`. `side_op` 0 loads `side_val`, 1 adds one (saturating at 4095), 2 subtracts one (saturating at 0), and 3 holds. The update is dropped if the command granted in that cycle is an active code 1, 2, 3 or 6 on the same index.
- R11: `rd_val` shows the stored value of semaphore `rd_idx` without delay.
- R12: After reset all semaphores read 0 and no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_pre | input | NCH | Per channel: 1 when the sequencer is before its transfer |
| cmd_valid | input | NCH | Per channel: command word present |
| cmd_word | input | 32*NCH | Command words, channel g in bits 32g+31:32g |
| to_dev_pend | input | CW | Outstanding transfers into the device |
| from_dev_pend | input | CW | Outstanding transfers out of the device |
| side_valid | input | 1 | Side-port update request |
| side_op | input | 2 | Side-port operation |
| side_idx | input | log2(NSEM) | Side-port semaphore index |
| side_val | input | 12 | Side-port load value |
| rd_idx | input | log2(NSEM) | Read-port index |
| grant | output | NCH | One-hot grant, combinational |
| grant_err | output | NCH | Reserved operation flag, qualified by grant |
| rd_val | output | 12 | Value of semaphore rd_idx |

## Verification
The bench builds the unit with three channels, eight semaphores and 4-bit pending counts. With three channels, a higher-priority channel can be blocked while two lower ones compete, so the priority choice can be checked. With eight semaphores, random indices and small random operands often hit the same semaphore. That makes wait conditions resolve, saturation get reached, and side-port collisions with granted writes happen often. Narrow pending counts make fenced commands block and release many times during the random phase.

// File: rtl/semcu_pkg.sv
package semcu_pkg;

    localparam int VAL_W  = 12;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_LOAD    = 3'd1,
        OP_UP      = 3'd2,
        OP_DOWN    = 3'd3,
        OP_WAIT_EQ = 3'd4,
        OP_WAIT_GE = 3'd5,
        OP_TAKE    = 3'd6,
        OP_BAD     = 3'd7
    } sem_op_e;

    typedef enum logic [1:0] {
        SIDE_LOAD = 2'd0,
        SIDE_UP   = 2'd1,
        SIDE_DOWN = 2'd2,
        SIDE_HOLD = 2'd3
    } side_op_e;

    typedef struct packed {
        logic           en;
        logic           fence_to;
        logic           fence_from;
        logic [1:0]     spare_hi;
        sem_op_e        op;
        logic           spare_mid;
        logic           pre;
        logic           spare_lo;
        logic [4:0]     idx;
        logic [3:0]     spare_val;
        logic [VAL_W-1:0] val;
    } sem_cmd_t;

    function automatic logic [VAL_W-1:0] sat_up(input logic [VAL_W-1:0] v);
        return (&v) ? v : v + VAL_W'(1);
    endfunction

    function automatic logic [VAL_W-1:0] sat_down(input logic [VAL_W-1:0] v);
        return (v == '0) ? v : v - VAL_W'(1);
    endfunction

endpackage

// File: rtl/sem_eval.sv
module sem_eval
    import semcu_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              stage_pre,
    input  logic              to_clear,
    input  logic              from_clear,
    input  logic [VAL_W-1:0]  cur_val,
    output logic              ready,
    output logic              wr,
    output logic [VAL_W-1:0]  wr_val,
    output logic              err
);
    sem_cmd_t c;
    logic     active;
    logic     fence_ok;
    logic     cond_ok;

    always_comb begin
        c        = sem_cmd_t'(cmd_word);
        active   = c.en && (c.pre == stage_pre);
        fence_ok = (!c.fence_to || to_clear) && (!c.fence_from || from_clear);
        cond_ok  = 1'b1;
        wr       = 1'b0;
        wr_val   = cur_val;
        unique case (c.op)
            OP_LOAD: begin
                wr     = active;
                wr_val = c.val;
            end
            OP_UP: begin
                wr     = active;
                wr_val = sat_up(cur_val);
            end
            OP_DOWN: begin
                wr     = active;
                wr_val = sat_down(cur_val);
            end
            OP_WAIT_EQ: cond_ok = (cur_val == c.val);
            OP_WAIT_GE: cond_ok = (cur_val >= c.val);
            OP_TAKE: begin
                cond_ok = (cur_val != '0);
                wr      = active;
                wr_val  = cur_val - VAL_W'(1);
            end
            default: cond_ok = 1'b1;
        endcase
        ready = !active || (fence_ok && cond_ok);
        err   = active && (c.op == OP_BAD);
    end

endmodule

// File: rtl/sem_prio_pick.sv
module sem_prio_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/sem_store.sv
module sem_store
    import semcu_pkg::*;
#(
    parameter int NSEM = 32,
    localparam int IW = (NSEM > 1) ? $clog2(NSEM) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IW-1:0]                    wr_idx,
    input  logic [VAL_W-1:0]                 wr_val,
    input  logic                             side_valid,
    input  logic [1:0]                       side_op,
    input  logic [IW-1:0]                    side_idx,
    input  logic [VAL_W-1:0]                 side_val,
    output logic [NSEM-1:0][VAL_W-1:0]       sem
);
    typedef struct packed {
        logic [NSEM-1:0][VAL_W-1:0] sem;
    } store_t;

    store_t s_d, s_q;
    logic   side_go;

    always_comb begin
        s_d     = s_q;
        side_go = side_valid && !(wr_en && (wr_idx == side_idx));
        if (side_go) begin
            unique case (side_op_e'(side_op))
                SIDE_LOAD: s_d.sem[side_idx] = side_val;
                SIDE_UP:   s_d.sem[side_idx] = sat_up(s_q.sem[side_idx]);
                SIDE_DOWN: s_d.sem[side_idx] = sat_down(s_q.sem[side_idx]);
                default:   s_d.sem[side_idx] = s_q.sem[side_idx];
            endcase
        end
        if (wr_en) begin
            s_d.sem[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sem = s_q.sem;

endmodule

// File: rtl/sem_cmd_unit.sv
module sem_cmd_unit
    import semcu_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NSEM = 32,
    parameter int CW   = 8,
    localparam int IW  = (NSEM > 1) ? $clog2(NSEM) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         stage_pre,
    input  logic [NCH-1:0]         cmd_valid,
    input  logic [NCH*WORD_W-1:0]  cmd_word,
    input  logic [CW-1:0]          to_dev_pend,
    input  logic [CW-1:0]          from_dev_pend,
    input  logic                   side_valid,
    input  logic [1:0]             side_op,
    input  logic [IW-1:0]          side_idx,
    input  logic [VAL_W-1:0]       side_val,
    input  logic [IW-1:0]          rd_idx,
    output logic [NCH-1:0]         grant,
    output logic [NCH-1:0]         grant_err,
    output logic [VAL_W-1:0]       rd_val
);
    localparam int WIN_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NSEM-1:0][VAL_W-1:0] sem_flat;
    logic [NCH-1:0]             ch_ready;
    logic [NCH-1:0]             ch_wr;
    logic [NCH-1:0]             ch_err;
    logic [NCH-1:0]             pick;
    logic [IW-1:0]              ch_idx  [NCH];
    logic [VAL_W-1:0]           ch_wval [NCH];
    logic [WIN_W-1:0]           win;
    logic                       win_any;
    logic                       to_clear;
    logic                       from_clear;
    logic                       wr_en;
    logic [IW-1:0]              wr_idx;
    logic [VAL_W-1:0]           wr_val;

    assign to_clear   = (to_dev_pend == '0);
    assign from_clear = (from_dev_pend == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_idx[g] = cmd_word[g*WORD_W + 16 +: IW];

        sem_eval i_eval (
            .cmd_word   (cmd_word[g*WORD_W +: WORD_W]),
            .stage_pre  (stage_pre[g]),
            .to_clear   (to_clear),
            .from_clear (from_clear),
            .cur_val    (sem_flat[ch_idx[g]]),
            .ready      (ch_ready[g]),
            .wr         (ch_wr[g]),
            .wr_val     (ch_wval[g]),
            .err        (ch_err[g])
        );
    end

    sem_prio_pick #(.N(NCH)) i_pick (
        .req (cmd_valid & ch_ready),
        .gnt (pick),
        .any (win_any),
        .idx (win)
    );

    assign grant     = pick;
    assign grant_err = pick & ch_err;
    assign wr_en     = win_any && ch_wr[win];
    assign wr_idx    = ch_idx[win];
    assign wr_val    = ch_wval[win];

    sem_store #(.NSEM(NSEM)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_val     (wr_val),
        .side_valid (side_valid),
        .side_op    (side_op),
        .side_idx   (side_idx),
        .side_val   (side_val),
        .sem        (sem_flat)
    );

    assign rd_val = sem_flat[rd_idx];

endmodule

// File: rtl/semcu_chk.sv
module semcu_chk
    import semcu_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NSEM = 32,
    parameter int CW   = 8,
    localparam int IW  = (NSEM > 1) ? $clog2(NSEM) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NCH-1:0]             stage_pre,
    input logic [NCH-1:0]             cmd_valid,
    input logic [NCH*WORD_W-1:0]      cmd_word,
    input logic [CW-1:0]              to_dev_pend,
    input logic [CW-1:0]              from_dev_pend,
    input logic [NCH-1:0]             grant,
    input logic [NCH-1:0]             grant_err,
    input logic [NSEM-1:0][VAL_W-1:0] sem_flat
);
    logic [NCH-1:0]   idle_cmd;
    logic             tk_hit;
    logic [IW-1:0]    tk_idx;
    logic             tk_seen_q;
    logic [IW-1:0]    tk_idx_q;
    logic [VAL_W-1:0] tk_old_q;

    always_comb begin
        sem_cmd_t w;
        idle_cmd = '0;
        tk_hit   = 1'b0;
        tk_idx   = '0;
        for (int g = 0; g < NCH; g++) begin
            w = sem_cmd_t'(cmd_word[g*WORD_W +: WORD_W]);
            idle_cmd[g] = cmd_valid[g] && !w.en;
            if (grant[g] && w.en && (w.pre == stage_pre[g]) && (w.op == OP_TAKE)) begin
                tk_hit = 1'b1;
                tk_idx = w.idx[IW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_seen_q <= 1'b0;
            tk_idx_q  <= '0;
            tk_old_q  <= '0;
        end else begin
            tk_seen_q <= tk_hit;
            tk_idx_q  <= tk_idx;
            tk_old_q  <= sem_flat[tk_idx];
        end
    end

    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~cmd_valid) == '0);

    p_err_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_err & ~grant) == '0);

    p_idle_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cmd != '0) |-> (grant != '0));

    p_take_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tk_seen_q |-> (tk_old_q != '0));

    p_take_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tk_seen_q |-> (sem_flat[tk_idx_q] == tk_old_q - VAL_W'(1)));

    for (genvar g = 0; g < NCH; g++) begin : g_fence
        sem_cmd_t fw;
        assign fw = sem_cmd_t'(cmd_word[g*WORD_W +: WORD_W]);

        p_fence_to_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[g] && fw.en && (fw.pre == stage_pre[g]) && fw.fence_to)
                |-> (to_dev_pend == '0));

        p_fence_from_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[g] && fw.en && (fw.pre == stage_pre[g]) && fw.fence_from)
                |-> (from_dev_pend == '0));
    end

endmodule

bind sem_cmd_unit semcu_chk #(.NCH(NCH), .NSEM(NSEM), .CW(CW)) i_chk (.*);

// File: tb/test_sem_cmd_unit.sv
module test_sem_cmd_unit;

    localparam int PERIOD = 10;
    localparam int NCH    = 3;
    localparam int NSEM   = 8;
    localparam int CW     = 4;
    localparam int IW     = 3;
    localparam int VW     = 12;

    logic              clk;
    logic              rst_n;
    logic [NCH-1:0]    stage_pre;
    logic [NCH-1:0]    cmd_valid;
    logic [NCH*32-1:0] cmd_word;
    logic [CW-1:0]     to_dev_pend;
    logic [CW-1:0]     from_dev_pend;
    logic              side_valid;
    logic [1:0]        side_op;
    logic [IW-1:0]     side_idx;
    logic [VW-1:0]     side_val;
    logic [IW-1:0]     rd_idx;
    logic [NCH-1:0]    grant;
    logic [NCH-1:0]    grant_err;
    logic [VW-1:0]     rd_val;

    logic [VW-1:0] exp_sem [NSEM];
    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    sem_cmd_unit #(.NCH(NCH), .NSEM(NSEM), .CW(CW)) i_sem_cmd_unit (
        .clk(clk), .rst_n(rst_n), .stage_pre(stage_pre), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .to_dev_pend(to_dev_pend), .from_dev_pend(from_dev_pend),
        .side_valid(side_valid), .side_op(side_op), .side_idx(side_idx),
        .side_val(side_val), .rd_idx(rd_idx), .grant(grant), .grant_err(grant_err),
        .rd_val(rd_val)
    );

    initial clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic en, input logic fto, input logic ffr,
                                       input int op, input logic pre, input int idx, input int val);
        return {en, fto, ffr, 2'b00, 3'(op), 1'b0, pre, 1'b0, 5'(idx), 4'b0000, 12'(val)};
    endfunction

    function automatic logic [31:0] wd(input int ch);
        return cmd_word[ch*32 +: 32];
    endfunction

    function automatic logic act(input int ch);
        return wd(ch)[31] && (wd(ch)[22] == stage_pre[ch]);
    endfunction

    function automatic logic rdy(input int ch);
        logic [31:0]   w;
        logic [VW-1:0] s;
        w = wd(ch);
        s = exp_sem[w[16 +: IW]];
        if (!act(ch)) return 1'b1;
        if (w[30] && to_dev_pend != 0) return 1'b0;
        if (w[29] && from_dev_pend != 0) return 1'b0;
        case (w[26:24])
            3'd4:    return s == w[11:0];
            3'd5:    return s >= w[11:0];
            3'd6:    return s != 0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int winner();
        for (int ch = 0; ch < NCH; ch++)
            if (cmd_valid[ch] && rdy(ch)) return ch;
        return -1;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic model_update(input int w);
        logic          wrote;
        logic [IW-1:0] widx;
        logic [31:0]   c;
        logic [VW-1:0] o;
        wrote = 1'b0;
        widx  = '0;
        if (w >= 0 && act(w)) begin
            c    = wd(w);
            widx = c[16 +: IW];
            o    = exp_sem[widx];
            case (c[26:24])
                3'd1: begin exp_sem[widx] = c[11:0]; wrote = 1'b1; end
                3'd2: begin exp_sem[widx] = (o == 12'hfff) ? o : o + 1; wrote = 1'b1; end
                3'd3: begin exp_sem[widx] = (o == 0) ? o : o - 1; wrote = 1'b1; end
                3'd6: begin exp_sem[widx] = o - 1; wrote = 1'b1; end
                default: ;
            endcase
        end
        if (side_valid && !(wrote && widx == side_idx)) begin
            o = exp_sem[side_idx];
            case (side_op)
                2'd0: exp_sem[side_idx] = side_val;
                2'd1: exp_sem[side_idx] = (o == 12'hfff) ? o : o + 1;
                2'd2: exp_sem[side_idx] = (o == 0) ? o : o - 1;
                default: ;
            endcase
        end
    endtask

    task automatic step(input string tag);
        int w;
        logic [NCH-1:0] eg, ee;
        #1;
        w  = winner();
        eg = '0;
        ee = '0;
        if (w >= 0) begin
            eg[w] = 1'b1;
            ee[w] = act(w) && (wd(w)[26:24] == 3'd7);
        end
        check(tag, "grant", 32'(grant), 32'(eg));
        check(tag, "grant_err", 32'(grant_err), 32'(ee));
        check(tag, "rd_val", 32'(rd_val), 32'(exp_sem[rd_idx]));
        @(posedge clk);
        model_update(w);
        @(negedge clk);
    endtask

    task automatic clear();
        cmd_valid     = '0;
        cmd_word      = '0;
        stage_pre     = '0;
        to_dev_pend   = '0;
        from_dev_pend = '0;
        side_valid    = 1'b0;
        side_op       = 2'd3;
        side_idx      = '0;
        side_val      = '0;
    endtask

    task automatic put(input int ch, input logic [31:0] w);
        cmd_valid[ch]         = 1'b1;
        cmd_word[ch*32 +: 32] = w;
    endtask

    task automatic side(input int op, input int idx, input int val);
        side_valid = 1'b1;
        side_op    = 2'(op);
        side_idx   = IW'(idx);
        side_val   = VW'(val);
    endtask

    task automatic peek(input string tag, input int idx, input int exp);
        rd_idx = IW'(idx);
        #1;
        check(tag, "rd_val", 32'(rd_val), 32'(exp));
    endtask

    task automatic gnt_is(input string tag, input int exp);
        #1;
        check(tag, "grant", 32'(grant), 32'(exp));
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NSEM; i++) exp_sem[i] = '0;
        clear();
        rd_idx = '0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        gnt_is("R12", 0);
        for (int i = 0; i < NSEM; i++) peek("R12", i, 0);
        step("R12");

        // R4: load and nop
        put(0, mk(1, 0, 0, 1, 0, 2, 100));
        step("R4");
        clear();
        peek("R4", 2, 100);
        put(0, mk(1, 0, 0, 0, 0, 2, 7));
        step("R4");
        clear();
        peek("R4", 2, 100);

        // R5: saturation at both ends
        put(0, mk(1, 0, 0, 1, 0, 3, 4095));
        step("R5");
        put(0, mk(1, 0, 0, 2, 0, 3, 0));
        step("R5");
        clear();
        peek("R5", 3, 4095);
        put(0, mk(1, 0, 0, 3, 0, 4, 0));
        step("R5");
        clear();
        peek("R5", 4, 0);

        // R6: wait-equal released by side increments, then wait-ge
        put(0, mk(1, 0, 0, 1, 0, 5, 3));
        step("R6");
        clear();
        put(1, mk(1, 0, 0, 4, 0, 5, 5));
        side(1, 5, 0);
        gnt_is("R6", 0);
        step("R6");
        gnt_is("R6", 0);
        step("R6");
        side_valid = 1'b0;
        gnt_is("R6", 3'b010);
        step("R6");
        put(1, mk(1, 0, 0, 5, 0, 5, 6));
        gnt_is("R6", 0);
        step("R6");
        put(1, mk(1, 0, 0, 5, 0, 5, 5));
        gnt_is("R6", 3'b010);
        step("R6");

        // R7: take blocks on zero, then consumes one
        clear();
        put(2, mk(1, 0, 0, 6, 0, 6, 0));
        side(0, 6, 2);
        gnt_is("R7", 0);
        step("R7");
        side_valid = 1'b0;
        gnt_is("R7", 3'b100);
        step("R7");
        clear();
        peek("R7", 6, 1);

        // R3: fences in each direction
        put(0, mk(1, 1, 0, 0, 0, 0, 0));
        to_dev_pend = 2;
        gnt_is("R3", 0);
        step("R3");
        to_dev_pend   = 0;
        from_dev_pend = 1;
        gnt_is("R3", 3'b001);
        step("R3");
        put(0, mk(1, 0, 1, 0, 0, 0, 0));
        gnt_is("R3", 0);
        step("R3");
        from_dev_pend = 0;
        gnt_is("R3", 3'b001);
        step("R3");

        // R8: reserved operation
        clear();
        put(0, mk(1, 0, 0, 7, 0, 1, 33));
        #1;
        check("R8", "grant_err", 32'(grant_err), 32'(3'b001));
        step("R8");
        clear();
        peek("R8", 1, 0);

        // R1: disabled command ignores fences and has no effect
        to_dev_pend   = 5;
        from_dev_pend = 5;
        put(1, mk(0, 1, 1, 1, 0, 1, 99));
        gnt_is("R1", 3'b010);
        step("R1");
        clear();
        peek("R1", 1, 0);

        // R2: stage mismatch passes, match applies
        stage_pre[0] = 1'b1;
        put(0, mk(1, 0, 0, 1, 0, 7, 55));
        gnt_is("R2", 3'b001);
        step("R2");
        peek("R2", 7, 0);
        put(0, mk(1, 0, 0, 1, 1, 7, 55));
        step("R2");
        clear();
        peek("R2", 7, 55);

        // R9: blocked channel 0, channels 1 and 2 ready
        put(0, mk(1, 0, 0, 4, 0, 0, 77));
        put(1, mk(1, 0, 0, 0, 0, 0, 0));
        put(2, mk(1, 0, 0, 0, 0, 0, 0));
        gnt_is("R9", 3'b010);
        step("R9");

        // R10: side port collision and plain side operations
        clear();
        put(0, mk(1, 0, 0, 1, 0, 1, 7));
        side(0, 1, 9);
        step("R10");
        clear();
        peek("R10", 1, 7);
        side(0, 1, 9);
        step("R10");
        side(2, 0, 0);
        step("R10");
        side(3, 1, 0);
        step("R10");
        clear();
        peek("R10", 1, 9);
        peek("R10", 0, 0);

        // R11 and R9: constrained random mix
        for (int it = 0; it < 4000; it++) begin
            clear();
            for (int ch = 0; ch < NCH; ch++) begin
                stage_pre[ch] = 1'($urandom % 2);
                if ($urandom % 4 != 0)
                    put(ch, mk(($urandom % 8) != 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
                               int'($urandom % 8), 1'($urandom % 2), int'($urandom % 8),
                               ($urandom % 4 == 0) ? int'($urandom % 4096) : int'($urandom % 6)));
            end
            if ($urandom % 4 == 0) to_dev_pend = CW'($urandom % 4);
            if ($urandom % 4 == 0) from_dev_pend = CW'($urandom % 4);
            if ($urandom % 2 == 0)
                side(int'($urandom % 4), int'($urandom % 8),
                     ($urandom % 3 == 0) ? int'($urandom % 4096) : int'($urandom % 6));
            rd_idx = IW'($urandom % 8);
            step("R11");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule